// File: doc/BRIEF.md
# Processor reset and boot sequencer

This block governs a small fixed-point DSP core from the moment reset is applied until its first instruction fetch. While the core is held, three clear strobes stay high. They force the core's stack pointers to empty, mask every interrupt and zero the mode-status register. Once the hold ends, the sequencer either requests a boot-load phase and waits for the loader to report completion, or it goes straight to fetching. In both cases fetching begins at program address 0x0000.

Two kinds of reset are handled. A cold start is marked by an asynchronous power-on input. It always keeps the core held for a fixed number of clock cycles, and for as long as the PLL reports no lock, even when the external reset pin is released earlier. A warm reset comes through the external reset pin while the clock keeps running. It needs no stabilization wait, but it takes effect only when the pin is held low long enough. A shorter glitch leaves the running core untouched. The reset pin is brought in through a two-flop synchronizer that asserts asynchronously and releases on a clock edge.

Boot entry depends on two conditions: the memory-map strap must be low and no bus request may be pending. If a request is pending when the hold ends, the sequencer parks until the request drops, then evaluates the strap again.

Top module: `rst_boot_seq`

## Requirements
- R1: While the core is held in reset, clrStack and clrModeStat are 1, and bootStart and fetchEn are 0.
- R2: While the core is held in reset, maskIrq is 1. It is 0 whenever fetchEn or bootStart is 1.
- R3: When the hold ends with busReq low and mapStrap equal to 0, bootStart goes to 1, and fetchEn stays 0 until bootDone is seen high.
- R4: fetchEn goes to 1 when bootDone is sampled high during the boot phase, or directly when the hold ends with mapStrap equal to 1 and busReq low. While fetchEn is 1, fetchAddr is 0x0000.
- R5: After powerOnN is released, the core stays held for at least LOCK_CYCLES rising clock edges (default 2000), even if rstN is already high.
- R6: A warm reset (rstN low while powerOnN stays high) that takes effect imposes no lock wait. With mapStrap equal to 1 and busReq low, fetchEn is 1 no later than the 4th rising edge after rstN rises.
- R7: A low pulse on rstN seen by fewer than MIN_PULSE rising edges after synchronization (default 8, two of which come from the synchronizer) is ignored. The strobes do not rise and fetchEn stays 1. A pulse spanning at least MIN_PULSE-2 edges puts the core into reset.
- R8: If busReq is high when the hold ends, neither bootStart nor fetchEn rises while busReq stays high. When busReq drops, the boot decision is made with the mapStrap value at that moment.
- R9: On a cold start the hold continues past LOCK_CYCLES for as long as pllLock is low, and ends once pllLock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| powerOnN | input | 1 | Active-low asynchronous power-on indication, marks a cold start |
| rstN | input | 1 | Active-low external reset pin |
| mapStrap | input | 1 | Memory-map strap; 0 selects boot loading |
| busReq | input | 1 | External bus request, high while pending |
| pllLock | input | 1 | PLL lock indication |
| bootDone | input | 1 | Boot loader completion handshake |
| clrStack | output | 1 | Forces stack pointers to empty |
| maskIrq | output | 1 | Masks all interrupts |
| clrModeStat | output | 1 | Clears the mode-status register |
| bootStart | output | 1 | Requests the boot-load phase (level) |
| fetchEn | output | 1 | Enables instruction fetch |
| fetchAddr | output | ADDR_W | Fetch start address |

## Verification
Every internal state shows directly on the outputs. A state register stuck in or wrongly entering the hold shows as clear strobes that are high or low at the wrong cycle. An error in the lock counter shows as a cold hold whose length differs from LOCK_CYCLES. This is measurable on the first cycle after the expected release. An error in the pulse-width counter shows up within about ten cycles of a glitch, either as a spurious drop of fetchEn or as a long reset that never reaches the core. A wrong boot decision shows on the first cycle after the hold ends, as the wrong one of bootStart or fetchEn.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

  typedef enum logic [1:0] {
    stHold    = 2'd0,
    stBusWait = 2'd1,
    stBoot    = 2'd2,
    stFetch   = 2'd3
  } seqState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic coldRun;
    logic coreClear;
    logic bootReq;
    logic fetchGo;
  } ctlStrobes_t;

  // datapath -> control status
  typedef struct packed {
    logic coldElapsed;
    logic warmHit;
    logic rstHigh;
  } dpStatus_t;

endpackage

// File: rtl/rbs_datapath.sv
module rbs_datapath
  import rbs_pkg::*;
#(
  parameter int LOCK_CYCLES = 2000,
  parameter int MIN_PULSE   = 8,
  parameter int ADDR_W      = 14,
  parameter int START_ADDR  = 0
) (
  input  logic              clk,
  input  logic              powerOnN,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  output dpStatus_t         sts,
  output logic              clrStack,
  output logic              maskIrq,
  output logic              clrModeStat,
  output logic              bootStart,
  output logic              fetchEn,
  output logic [ADDR_W-1:0] fetchAddr
);

  localparam int CW = $clog2(LOCK_CYCLES + 1);
  localparam int PW = $clog2(MIN_PULSE + 1);
  localparam logic [CW-1:0] COLD_LAST = CW'(LOCK_CYCLES - 1);
  localparam logic [PW-1:0] PULSE_MAX = PW'(MIN_PULSE);
  localparam logic [PW-1:0] PULSE_HIT = PW'(MIN_PULSE - 1);

  // two-flop reset synchronizer: asynchronous assert, synchronous release
  logic [1:0] syncQ;
  logic       rstSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 2'b00;
    else       syncQ <= {syncQ[0], 1'b1};
  end
  assign rstSync = syncQ[1];

  // cold-start lock counter, saturates at its last value
  logic [CW-1:0] coldCnt;
  logic          coldAtEnd;
  assign coldAtEnd = (coldCnt == COLD_LAST);

  always_ff @(posedge clk or negedge powerOnN) begin
    if (!powerOnN)                  coldCnt <= '0;
    else if (ctl.coldRun && !coldAtEnd) coldCnt <= coldCnt + 1'b1;
  end

  // warm-reset pulse-width counter
  logic [PW-1:0] lowCnt;

  always_ff @(posedge clk or negedge powerOnN) begin
    if (!powerOnN)              lowCnt <= '0;
    else if (rstSync)           lowCnt <= '0;
    else if (lowCnt != PULSE_MAX) lowCnt <= lowCnt + 1'b1;
  end

  assign sts.coldElapsed = coldAtEnd;
  assign sts.warmHit     = !rstSync && (lowCnt >= PULSE_HIT);
  assign sts.rstHigh     = rstSync;

  // outputs toward the core
  assign clrStack    = ctl.coreClear;
  assign maskIrq     = ctl.coreClear;
  assign clrModeStat = ctl.coreClear;
  assign bootStart   = ctl.bootReq;
  assign fetchEn     = ctl.fetchGo;
  assign fetchAddr   = ctl.fetchGo ? ADDR_W'(START_ADDR) : '0;

endmodule

// File: rtl/rbs_control.sv
module rbs_control
  import rbs_pkg::*;
(
  input  logic        clk,
  input  logic        powerOnN,
  input  logic        mapStrap,
  input  logic        busReq,
  input  logic        pllLock,
  input  logic        bootDone,
  input  dpStatus_t   sts,
  output ctlStrobes_t ctl
);

  seqState_e state, stateNxt;
  logic      coldFlag;

  function automatic seqState_e pickPath(input logic req, input logic strap);
    if (req)        return stBusWait;
    else if (strap) return stFetch;
    else            return stBoot;
  endfunction

  always_ff @(posedge clk or negedge powerOnN) begin
    if (!powerOnN) begin
      state    <= stHold;
      coldFlag <= 1'b1;
    end else begin
      state <= stateNxt;
      if (coldFlag && sts.coldElapsed && pllLock) coldFlag <= 1'b0;
    end
  end

  always_comb begin
    stateNxt = state;
    unique case (state)
      stHold: begin
        if (!coldFlag && sts.rstHigh) stateNxt = pickPath(busReq, mapStrap);
      end
      stBusWait: begin
        if (sts.warmHit)  stateNxt = stHold;
        else if (!busReq) stateNxt = pickPath(1'b0, mapStrap);
      end
      stBoot: begin
        if (sts.warmHit)  stateNxt = stHold;
        else if (bootDone) stateNxt = stFetch;
      end
      stFetch: begin
        if (sts.warmHit)  stateNxt = stHold;
      end
      default: stateNxt = stHold;
    endcase
  end

  assign ctl.coldRun   = coldFlag;
  assign ctl.coreClear = (state == stHold);
  assign ctl.bootReq   = (state == stBoot);
  assign ctl.fetchGo   = (state == stFetch);

endmodule

// File: rtl/rst_boot_seq.sv
module rst_boot_seq
  import rbs_pkg::*;
#(
  parameter int LOCK_CYCLES = 2000,
  parameter int MIN_PULSE   = 8,
  parameter int ADDR_W      = 14,
  parameter int START_ADDR  = 0
) (
  input  logic              clk,
  input  logic              powerOnN,
  input  logic              rstN,
  input  logic              mapStrap,
  input  logic              busReq,
  input  logic              pllLock,
  input  logic              bootDone,
  output logic              clrStack,
  output logic              maskIrq,
  output logic              clrModeStat,
  output logic              bootStart,
  output logic              fetchEn,
  output logic [ADDR_W-1:0] fetchAddr
);

  ctlStrobes_t ctl;
  dpStatus_t   sts;

  rbs_control u_ctl (
    .clk      (clk),
    .powerOnN (powerOnN),
    .mapStrap (mapStrap),
    .busReq   (busReq),
    .pllLock  (pllLock),
    .bootDone (bootDone),
    .sts      (sts),
    .ctl      (ctl)
  );

  rbs_datapath #(
    .LOCK_CYCLES (LOCK_CYCLES),
    .MIN_PULSE   (MIN_PULSE),
    .ADDR_W      (ADDR_W),
    .START_ADDR  (START_ADDR)
  ) u_dp (
    .clk         (clk),
    .powerOnN    (powerOnN),
    .rstN        (rstN),
    .ctl         (ctl),
    .sts         (sts),
    .clrStack    (clrStack),
    .maskIrq     (maskIrq),
    .clrModeStat (clrModeStat),
    .bootStart   (bootStart),
    .fetchEn     (fetchEn),
    .fetchAddr   (fetchAddr)
  );

endmodule

// File: rtl/rbs_checker.sv
module rbs_checker #(
  parameter int LOCK_CYCLES = 2000,
  parameter int ADDR_W      = 14
) (
  input logic              clk,
  input logic              powerOnN,
  input logic              mapStrap,
  input logic              busReq,
  input logic              bootDone,
  input logic              clrStack,
  input logic              maskIrq,
  input logic              clrModeStat,
  input logic              bootStart,
  input logic              fetchEn,
  input logic [ADDR_W-1:0] fetchAddr
);

  localparam int CW = $clog2(LOCK_CYCLES + 2);
  localparam logic [CW-1:0] SEEN_MAX = CW'(LOCK_CYCLES + 1);

  // rising edges seen since power-on release
  logic [CW-1:0] coldSeen;
  always_ff @(posedge clk or negedge powerOnN) begin
    if (!powerOnN)              coldSeen <= '0;
    else if (coldSeen != SEEN_MAX) coldSeen <= coldSeen + 1'b1;
  end

  // R1: the hold excludes boot and fetch
  a_r1_hold_exclusive: assert property (@(posedge clk) disable iff (!powerOnN)
    (clrStack || clrModeStat) |-> (!bootStart && !fetchEn));

  // R2: interrupts unmasked once running
  a_r2_mask_released: assert property (@(posedge clk) disable iff (!powerOnN)
    (fetchEn || bootStart) |-> !maskIrq);

  // R3: boot entry needs strap 0 and no pending request
  a_r3_boot_gate: assert property (@(posedge clk) disable iff (!powerOnN)
    $rose(bootStart) |-> ($past(!mapStrap) && $past(!busReq)));

  // R3: leaving boot for fetch needs the completion handshake
  a_r3_boot_done: assert property (@(posedge clk) disable iff (!powerOnN)
    ($rose(fetchEn) && $past(bootStart)) |-> $past(bootDone));

  // R4: fetch starts at address zero
  a_r4_start_addr: assert property (@(posedge clk) disable iff (!powerOnN)
    fetchEn |-> (fetchAddr == '0));

  // R5: no activity before the lock window has elapsed
  a_r5_cold_window: assert property (@(posedge clk) disable iff (!powerOnN)
    (bootStart || fetchEn) |-> (coldSeen >= CW'(LOCK_CYCLES)));

  // R8: parked while a bus request is pending
  a_r8_bus_park: assert property (@(posedge clk) disable iff (!powerOnN)
    (busReq && !clrStack && !bootStart && !fetchEn) |=> (!bootStart && !fetchEn));

endmodule

bind rst_boot_seq rbs_checker #(
  .LOCK_CYCLES (LOCK_CYCLES),
  .ADDR_W      (ADDR_W)
) u_chk (
  .clk         (clk),
  .powerOnN    (powerOnN),
  .mapStrap    (mapStrap),
  .busReq      (busReq),
  .bootDone    (bootDone),
  .clrStack    (clrStack),
  .maskIrq     (maskIrq),
  .clrModeStat (clrModeStat),
  .bootStart   (bootStart),
  .fetchEn     (fetchEn),
  .fetchAddr   (fetchAddr)
);

// File: tb/sim_rst_boot_seq.sv
module sim_rst_boot_seq;

  localparam int CLK_PERIOD = 10;
  localparam int LOCK       = 2000;
  localparam int MINP       = 8;
  localparam int AW         = 14;

  logic clk = 1'b0;
  logic powerOnN, rstN, mapStrap, busReq, pllLock, bootDone;
  logic clrStack, maskIrq, clrModeStat, bootStart, fetchEn;
  logic [AW-1:0] fetchAddr;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  // expected event codes: 1 = boot request rises, 2 = fetch enable rises
  int expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_boot_seq #(.LOCK_CYCLES(LOCK), .MIN_PULSE(MINP), .ADDR_W(AW)) u0 (
    .clk(clk), .powerOnN(powerOnN), .rstN(rstN), .mapStrap(mapStrap),
    .busReq(busReq), .pllLock(pllLock), .bootDone(bootDone),
    .clrStack(clrStack), .maskIrq(maskIrq), .clrModeStat(clrModeStat),
    .bootStart(bootStart), .fetchEn(fetchEn), .fetchAddr(fetchAddr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic expectEvent(input int code);
    expQ.push_back(code);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops an expected event on every rising boot or fetch output
  logic prevBoot = 1'b0, prevFetch = 1'b0;
  always @(negedge clk) begin
    if (bootStart && !prevBoot) begin
      if (expQ.size() == 0) check(1'b0, "R3 unexpected boot", 1, 0);
      else begin
        int e;
        e = expQ.pop_front();
        check(e == 1, "R3 boot event order", 1, e);
      end
    end
    if (fetchEn && !prevFetch) begin
      if (expQ.size() == 0) check(1'b0, "R4 unexpected fetch", 2, 0);
      else begin
        int e;
        e = expQ.pop_front();
        check(e == 2, "R4 fetch event order", 2, e);
      end
      check(fetchAddr == '0, "R4 fetch address", int'(fetchAddr), 0);
    end
    prevBoot  <= bootStart;
    prevFetch <= fetchEn;
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      summary();
    end
  end

  initial begin
    int holdCnt;
    int lat;
    powerOnN = 1'b0; rstN = 1'b0; mapStrap = 1'b0; busReq = 1'b0;
    pllLock = 1'b1; bootDone = 1'b0;
    cyc(3);
    // R1 R2 reset state
    check(clrStack == 1'b1, "R1 clrStack in reset", clrStack, 1);
    check(clrModeStat == 1'b1, "R1 clrModeStat in reset", clrModeStat, 1);
    check(maskIrq == 1'b1, "R2 maskIrq in reset", maskIrq, 1);
    check(!bootStart && !fetchEn, "R1 idle in reset", {bootStart, fetchEn}, 0);

    // R5 cold start, pin released early
    expectEvent(1);
    powerOnN = 1'b1;
    cyc(1);
    rstN = 1'b1;
    holdCnt = 1;
    while (clrStack && holdCnt < 3000) begin
      cyc(1);
      if (clrStack) holdCnt++;
    end
    check(holdCnt >= LOCK && holdCnt <= LOCK + 2, "R5 cold hold length", holdCnt, LOCK);

    // R3 boot phase waits for the handshake
    cyc(1);
    check(bootStart == 1'b1, "R3 boot requested", bootStart, 1);
    check(maskIrq == 1'b0, "R2 unmasked in boot", maskIrq, 0);
    cyc(5);
    check(fetchEn == 1'b0, "R3 no fetch before bootDone", fetchEn, 0);
    expectEvent(2);
    bootDone = 1'b1;
    cyc(1);
    bootDone = 1'b0;
    cyc(2);
    check(fetchEn == 1'b1, "R4 fetch after boot", fetchEn, 1);
    check(fetchAddr == '0, "R4 address zero", int'(fetchAddr), 0);

    // R7 short glitch ignored
    rstN = 1'b0;
    cyc(1);
    rstN = 1'b1;
    begin
      bit sawClr = 0, sawDrop = 0;
      for (int i = 0; i < 12; i++) begin
        cyc(1);
        if (clrStack) sawClr = 1;
        if (!fetchEn) sawDrop = 1;
      end
      check(!sawClr, "R7 glitch gives no clear", sawClr, 0);
      check(!sawDrop, "R7 fetch kept through glitch", sawDrop, 0);
    end

    // R6 warm reset, direct fetch with strap 1
    mapStrap = 1'b1;
    rstN = 1'b0;
    cyc(10);
    check(clrStack && maskIrq && clrModeStat, "R6 warm reset clears", clrStack, 1);
    check(fetchEn == 1'b0, "R1 fetch off in warm reset", fetchEn, 0);
    expectEvent(2);
    rstN = 1'b1;
    lat = 0;
    while (!fetchEn && lat < 50) begin
      cyc(1);
      lat++;
    end
    check(lat <= 4, "R6 warm release latency", lat, 4);
    check(bootStart == 1'b0, "R4 strap 1 skips boot", bootStart, 0);

    // R8 pending bus request parks the sequencer
    mapStrap = 1'b0;
    busReq = 1'b1;
    rstN = 1'b0;
    cyc(10);
    rstN = 1'b1;
    cyc(10);
    check(!clrStack, "R8 hold ended", clrStack, 0);
    check(!bootStart && !fetchEn, "R8 parked on bus request", {bootStart, fetchEn}, 0);
    expectEvent(1);
    busReq = 1'b0;
    cyc(2);
    check(bootStart == 1'b1, "R8 boot after request drops", bootStart, 1);
    expectEvent(2);
    bootDone = 1'b1;
    cyc(1);
    bootDone = 1'b0;
    cyc(2);
    check(fetchEn == 1'b1, "R4 fetch after second boot", fetchEn, 1);

    // R9 cold start with late PLL lock
    pllLock = 1'b0;
    mapStrap = 1'b1;
    powerOnN = 1'b0;
    cyc(2);
    powerOnN = 1'b1;
    cyc(LOCK + 20);
    check(clrStack == 1'b1, "R9 held while unlocked", clrStack, 1);
    expectEvent(2);
    pllLock = 1'b1;
    cyc(4);
    check(fetchEn == 1'b1, "R9 fetch after lock", fetchEn, 1);

    cyc(2);
    check(expQ.size() == 0, "R4 all expected events seen", expQ.size(), 0);
    done = 1;
    summary();
  end

endmodule